// File: doc/BRIEF.md
# Countdown Alarm with Wakeup

A seconds-resolution alarm for an always-on power domain. Software loads a count of seconds into a 32-bit countdown register over a simple 32-bit register bus, then sets a run bit. Each pulse on the 1 Hz tick input removes one second from the count while the run bit is set. When the count reaches zero the block latches a sticky pending flag. That flag drives an interrupt output when the interrupt enable is set, and a wakeup request when the wakeup enable is set.

Software clears the pending flag by writing one to its status bit. To re-arm the alarm, software first drops the run bit, writes zero to the count, waits, writes the new count and sets the run bit again. The tick source is outside the block: it arrives as a one-cycle pulse in the block's clock domain.

The register map is fixed: 0x20 load count, 0x24 remaining count (read only), 0x28 run, 0x2C interrupt enable, 0x30 status, 0x50 wakeup enable. Reads are combinational on the address.

Top module: `sec_alarm_top`

## Requirements
- R1: After reset every register reads zero and irq_o and wake_o are low.
- R2: A write to offset 0x20 loads all 32 bits of the count. Offset 0x24 returns the remaining count, and offset 0x20 returns the value last loaded. Both are correct up to 0xFFFFFFFF.
- R3: On a tick_i pulse the remaining count drops by exactly one, but only while bit 0 of offset 0x28 is 1 and the count is nonzero. Otherwise it holds, and it never wraps below zero.
- R4: The tick that takes the count from 1 to 0 sets the pending flag, which is bit 0 of offset 0x30. A count that is loaded as zero never sets the flag.
- R5: Writing 1 to bit 0 of offset 0x30 clears the pending flag. Writing 0 there leaves it unchanged, and further ticks at zero leave it set.
- R6: If a clear write and an expiring tick fall in the same cycle, the pending flag is set afterwards.
- R7: irq_o is high exactly when the pending flag and bit 0 of offset 0x2C are both 1.
- R8: wake_o is high exactly when the pending flag and bit 0 of offset 0x50 are both 1.
- R9: The registers at 0x28, 0x2C and 0x50 store and return only bit 0, and their upper bits read zero. Offsets outside the map read zero, and writes to them change nothing.
- R10: A count load that falls in the same cycle as a tick takes effect, and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Alarm interrupt |
| wake_o | output | 1 | Wakeup request |

## Verification
The bench sweeps every count from 1 to 10 against all four combinations of interrupt and wakeup enable. It checks the remaining count before each tick. A design that expires one tick early or one tick late, or that routes the flag to the wrong output, fails here. Extra ticks at zero catch a counter that wraps to 0xFFFFFFFF or re-arms the flag. A load of the all-ones value catches a truncated counter. The bench drives a clear and an expiry in the same cycle, and a load and a tick in the same cycle, to catch a design that lets the clear or the tick win. It checks that a count loaded as zero never raises the flag. It also writes to an unmapped offset, which would expose a decoder that aliases.

// File: rtl/sec_alarm_pkg.sv
package sec_alarm_pkg;
  localparam logic [7:0] OFF_LOAD  = 8'h20;
  localparam logic [7:0] OFF_LEFT  = 8'h24;
  localparam logic [7:0] OFF_RUN   = 8'h28;
  localparam logic [7:0] OFF_IRQEN = 8'h2C;
  localparam logic [7:0] OFF_STAT  = 8'h30;
  localparam logic [7:0] OFF_WAKE  = 8'h50;

  typedef struct packed {
    logic run;
    logic irq_en;
    logic wake_en;
  } ctrl_t;
endpackage

// File: rtl/sec_alarm_counter.sv
module sec_alarm_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step     = tick_i & run_i & (cnt_q != '0) & ~load_i;
  assign expire_o = step & (cnt_q == CNT_W'(1));
  assign cnt_o    = cnt_q;

  // load wins over a coincident tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step)   cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/sec_alarm_regs.sv
module sec_alarm_regs
  import sec_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              expire_i,
  output ctrl_t             ctrl_o,
  output logic              pend_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic sel_load, sel_left, sel_run, sel_irqen, sel_stat, sel_wake;
  logic clr;
  ctrl_t            ctrl_q;
  logic             pend_q;
  logic [CNT_W-1:0] reload_q;

  assign sel_load  = addr_i == ADDR_W'(OFF_LOAD);
  assign sel_left  = addr_i == ADDR_W'(OFF_LEFT);
  assign sel_run   = addr_i == ADDR_W'(OFF_RUN);
  assign sel_irqen = addr_i == ADDR_W'(OFF_IRQEN);
  assign sel_stat  = addr_i == ADDR_W'(OFF_STAT);
  assign sel_wake  = addr_i == ADDR_W'(OFF_WAKE);

  assign load_o     = we_i & sel_load;
  assign load_val_o = wdata_i[CNT_W-1:0];
  assign clr        = we_i & sel_stat & wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      pend_q   <= 1'b0;
      reload_q <= '0;
    end else begin
      if (we_i && sel_run)   ctrl_q.run     <= wdata_i[0];
      if (we_i && sel_irqen) ctrl_q.irq_en  <= wdata_i[0];
      if (we_i && sel_wake)  ctrl_q.wake_en <= wdata_i[0];
      if (load_o)            reload_q       <= load_val_o;
      // set beats clear
      pend_q <= expire_i | (pend_q & ~clr);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_load)       rdata_o = DATA_W'(reload_q);
    else if (sel_left)  rdata_o = DATA_W'(cnt_i);
    else if (sel_run)   rdata_o = DATA_W'(ctrl_q.run);
    else if (sel_irqen) rdata_o = DATA_W'(ctrl_q.irq_en);
    else if (sel_stat)  rdata_o = DATA_W'(pend_q);
    else if (sel_wake)  rdata_o = DATA_W'(ctrl_q.wake_en);
  end

  assign ctrl_o = ctrl_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/sec_alarm_top.sv
module sec_alarm_top
  import sec_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  ctrl_t            ctrl;
  logic             pend_q;
  logic             load_w;
  logic [CNT_W-1:0] load_val_w;
  logic [CNT_W-1:0] cnt_q;
  logic             expire_w;

  sec_alarm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cnt_i     (cnt_q),
    .expire_i  (expire_w),
    .ctrl_o    (ctrl),
    .pend_o    (pend_q),
    .load_o    (load_w),
    .load_val_o(load_val_w),
    .rdata_o   (rdata_o)
  );

  sec_alarm_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .run_i     (ctrl.run),
    .load_i    (load_w),
    .load_val_i(load_val_w),
    .cnt_o     (cnt_q),
    .expire_o  (expire_w)
  );

  assign irq_o  = pend_q & ctrl.irq_en;
  assign wake_o = pend_q & ctrl.wake_en;
endmodule

// File: rtl/sec_alarm_chk.sv
module sec_alarm_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             load_i,
  input logic [CNT_W-1:0] load_val_i,
  input logic             clr_i,
  input logic             run_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             pend_i,
  input logic             irq_i,
  input logic             wake_i
);
  a_r3_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && run_i && (cnt_i != '0) && !load_i |=> cnt_i == $past(cnt_i) - CNT_W'(1));

  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) && !load_i |=> cnt_i == '0);

  a_r3_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !load_i |=> $stable(cnt_i));

  a_r4_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && run_i && (cnt_i == CNT_W'(1)) && !load_i |=> pend_i);

  a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_i && !(tick_i && run_i && (cnt_i == CNT_W'(1)) && !load_i) |=> !pend_i);

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i && !clr_i |=> pend_i);

  a_r7_irq_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_i |-> !irq_i);

  a_r8_wake_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_i |-> !wake_i);

  a_r10_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_i == $past(load_val_i));
endmodule

bind sec_alarm_top sec_alarm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .load_i    (load_w),
  .load_val_i(load_val_w),
  .clr_i     (we_i && (addr_i == ADDR_W'(sec_alarm_pkg::OFF_STAT)) && wdata_i[0]),
  .run_i     (ctrl.run),
  .cnt_i     (cnt_q),
  .pend_i    (pend_q),
  .irq_i     (irq_o),
  .wake_i    (wake_o)
);

// File: tb/sec_alarm_top_tb_top.sv
`timescale 1ns/1ps
module sec_alarm_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wake;
  int          n_chk = 0;
  int          n_err = 0;
  logic [31:0] d;

  always #10 clk = ~clk;

  sec_alarm_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); we = 1'b1; addr = a; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic pulse;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); we = 1'b1; addr = a; wdata = v; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); we = 1'b0; addr = a;
    #2 v = rdata;
  endtask

  task automatic arm(input logic [31:0] n, input logic ie, input logic wk);
    wr(8'h28, 0); wr(8'h30, 1); wr(8'h20, 0); wr(8'h20, n);
    wr(8'h2C, {31'b0, ie}); wr(8'h50, {31'b0, wk}); wr(8'h28, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    foreach (sec_alarm_tb_offs[i]) begin
      rd(sec_alarm_tb_offs[i], d); chk("R1 reset read", d, 0);
    end
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 wake", {31'b0, wake}, 0);

    // R9 bit-0-only control regs, unmapped offsets
    wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C, d); chk("R9 irqen bit0", d, 1);
    wr(8'h2C, 32'hFFFF_FFFE); rd(8'h2C, d); chk("R9 irqen upper", d, 0);
    wr(8'h50, 32'h8000_0001); rd(8'h50, d); chk("R9 wake bit0", d, 1);
    wr(8'h50, 0);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, d); chk("R9 unmapped read", d, 0);
    rd(8'h28, d); chk("R9 unmapped no run", d, 0);
    rd(8'h20, d); chk("R9 unmapped no load", d, 0);
    rd(8'h2C, d); chk("R9 unmapped no irqen", d, 0);

    // R2 full-width load
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R2 load readback", d, 32'hFFFF_FFFF);
    rd(8'h24, d); chk("R2 left readback", d, 32'hFFFF_FFFF);
    wr(8'h28, 1); pulse();
    rd(8'h24, d); chk("R3 max dec", d, 32'hFFFF_FFFE);
    rd(8'h20, d); chk("R2 load held", d, 32'hFFFF_FFFF);

    // R3 disabled holds
    wr(8'h28, 0); wr(8'h20, 5);
    for (int k = 0; k < 3; k++) pulse();
    rd(8'h24, d); chk("R3 disabled hold", d, 5);

    // R4 zero load never expires
    wr(8'h20, 0); wr(8'h28, 1); pulse(); pulse();
    rd(8'h30, d); chk("R4 zero load no pend", d, 0);
    rd(8'h24, d); chk("R3 zero stays", d, 0);

    // Sweep counts and enable combinations
    for (int n = 1; n <= 10; n++) begin
      for (int m = 0; m < 4; m++) begin
        arm(n, m[0], m[1]);
        for (int k = 0; k < n; k++) begin
          rd(8'h24, d); chk("R3 step count", d, n - k);
          rd(8'h30, d); chk("R4 early pend", d, 0);
          pulse();
        end
        rd(8'h24, d); chk("R3 reached zero", d, 0);
        rd(8'h30, d); chk("R4 pend set", d, 1);
        chk("R7 irq", {31'b0, irq}, {31'b0, m[0]});
        chk("R8 wake", {31'b0, wake}, {31'b0, m[1]});
        pulse();
        rd(8'h24, d); chk("R3 no underflow", d, 0);
        rd(8'h30, d); chk("R5 sticky", d, 1);
        wr(8'h30, 32'hFFFF_FFFE);
        rd(8'h30, d); chk("R5 write0 keeps", d, 1);
        wr(8'h30, 1);
        rd(8'h30, d); chk("R5 clear", d, 0);
        chk("R7 irq cleared", {31'b0, irq}, 0);
        chk("R8 wake cleared", {31'b0, wake}, 0);
      end
    end

    // R6 clear and expiry together
    arm(1, 1'b1, 1'b1);
    wr_tick(8'h30, 1);
    rd(8'h30, d); chk("R6 set wins", d, 1);
    chk("R6 irq", {31'b0, irq}, 1);
    wr(8'h30, 1); rd(8'h30, d); chk("R6 later clear", d, 0);

    // R10 load and tick together
    arm(5, 1'b0, 1'b0);
    wr_tick(8'h20, 9);
    rd(8'h24, d); chk("R10 load wins", d, 9);
    pulse();
    rd(8'h24, d); chk("R10 then dec", d, 8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  localparam logic [7:0] sec_alarm_tb_offs [6] = '{8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h50};
endmodule